// File: doc/BRIEF.md
# Radio channel-change sequencer

This block runs on the host side of a narrow-band packet transceiver and moves the radio to a new operating channel. Firmware or a higher-level controller supplies a channel number and a one-cycle start pulse. The block then drives a generic register-master port through a fixed sequence of accesses.

First it programs the channel-select register. Next it toggles the RF reset bit without disturbing the other bits of the RF control register. It does this with one read followed by two write-backs. Finally it waits out the radio's mandatory settling time and signals completion.

The register port is a plain request/acknowledge handshake. It carries a space selector (short or long), an address, a write strobe, write data and read data. A separate serializer is expected to turn each request into a bus transaction. Channels outside the supported band are rejected at once, and no access is made for them.

Top module: `chan_switch_seq`

## Requirements
- R1: After reset, busy, done, error and reg_req are all low.
- R2: A start in idle with a channel below 11 or above 26 gives a single-cycle error pulse in the next cycle. It makes no register access and leaves busy low.
- R3: For a valid channel, the first access is a long-space write (reg_long=1, reg_we=1) to address 0x200. Its data is the channel minus 11 in bits 7:4, with bits 1:0 set to 1 and bits 3:2 at 0.
- R4: The second access is a short-space read (reg_long=0, reg_we=0) of address 0x036.
- R5: The third access is a short-space write to 0x036 of the value read with bit 2 forced to 1.
- R6: The fourth access is a short-space write to 0x036 of the value read with bit 2 forced to 0.
- R7: reg_req stays high with unchanged address, space, strobe and data until reg_ack is seen. Exactly one access is made per acknowledge.
- R8: done rises exactly 192 × CLK_MHZ clock cycles after the clock edge that accepts the fourth access.
- R9: busy is high from the cycle after an accepted start until done. done lasts one cycle, and busy is low while it is high.
- R10: A start while busy is ignored. It adds no access, raises no error and does not start a second sequence after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to change channel |
| channel | input | 5 | Requested channel number |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle pulse for an out-of-range channel |
| reg_req | output | 1 | Register access request |
| reg_long | output | 1 | 1 selects long address space, 0 short |
| reg_we | output | 1 | 1 write, 0 read |
| reg_addr | output | 10 | Register address |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data, valid with reg_ack |
| reg_ack | input | 1 | Access complete |

## Verification
The bench targets the band edges 10, 11, 26 and 27, plus the values 0 and 31. A wrong range compare would either touch the radio on a bad channel or reject a good one. It also catches an off-by-one in the offset, which would program the wrong select nibble.

The acknowledge latency varies at random, and the read value is random. A design that advanced without the acknowledge, or that rebuilt the write-backs from a constant, would log the wrong accesses. The settle window is counted to the exact cycle. A start injected in mid-sequence would expose a design that restarts or flags an error while busy.

// File: rtl/chan_switch_seq.sv
module chan_switch_seq #(
  parameter int CLK_MHZ   = 125,
  parameter int SETTLE_US = 192,
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter int CH_W      = 5,
  parameter int CH_LO     = 11,
  parameter int CH_HI     = 26,
  parameter int SEL_ADDR  = 'h200,
  parameter int CTL_ADDR  = 'h036,
  parameter int RST_BIT   = 2,
  parameter int SEL_LOW   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CH_W-1:0]   channel,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              reg_req,
  output logic              reg_long,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic              reg_ack
);
  localparam int SETTLE_CYC = SETTLE_US * CLK_MHZ;
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [DATA_W-1:0] RST_MASK = DATA_W'(1) << RST_BIT;

  typedef enum logic [2:0] {S_IDLE, S_SEL, S_RD, S_SET, S_CLR, S_WAIT} state_t;

  state_t            state;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] ctl, sel;
  logic              ch_ok;
  logic [DATA_W-1:0] sel_val;

  assign ch_ok   = channel >= CH_W'(CH_LO) && channel <= CH_W'(CH_HI);
  assign sel_val = (DATA_W'(channel - CH_W'(CH_LO)) << 4) | DATA_W'(SEL_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      ctl   <= '0;
      sel   <= '0;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (ch_ok) begin
            sel   <= sel_val;
            state <= S_SEL;
          end else error <= 1'b1;
        end
        S_SEL: if (reg_ack) state <= S_RD;
        S_RD: if (reg_ack) begin
          ctl   <= reg_rdata;
          state <= S_SET;
        end
        S_SET: if (reg_ack) state <= S_CLR;
        S_CLR: if (reg_ack) begin
          cnt   <= CNT_W'(SETTLE_CYC - 1);
          state <= S_WAIT;
        end
        S_WAIT: if (cnt == '0) begin
          done  <= 1'b1;
          state <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy     = state != S_IDLE;
  assign reg_req  = state inside {S_SEL, S_RD, S_SET, S_CLR};
  assign reg_long = state == S_SEL;
  assign reg_we   = state inside {S_SEL, S_SET, S_CLR};

  always_comb begin
    reg_addr  = ADDR_W'(CTL_ADDR);
    reg_wdata = '0;
    case (state)
      S_SEL: begin
        reg_addr  = ADDR_W'(SEL_ADDR);
        reg_wdata = sel;
      end
      S_SET: reg_wdata = ctl | RST_MASK;
      S_CLR: reg_wdata = ctl & ~RST_MASK;
      default: ;
    endcase
  end
endmodule

// File: rtl/chan_switch_seq_chk.sv
module chan_switch_seq_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic              reg_req,
  input logic              reg_ack,
  input logic              reg_long,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata
);
  p_hold_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_ack |=> reg_req && $stable(reg_addr) && $stable(reg_long)
                            && $stable(reg_we) && $stable(reg_wdata));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

  p_busy_from_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_error_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !busy && !reg_req && !done);

  p_error_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !$past(busy));

  p_req_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |-> busy);
endmodule

bind chan_switch_seq chan_switch_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .error(error), .reg_req(reg_req), .reg_ack(reg_ack), .reg_long(reg_long),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/chan_switch_seq_tb_top.sv
module chan_switch_seq_tb_top;
  localparam int CLK_MHZ = 125;
  localparam int SETTLE_CYC = 192 * CLK_MHZ;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, reg_ack = 1'b0;
  logic [4:0] channel = '0;
  logic [7:0] reg_rdata = '0;
  logic busy, done, error, reg_req, reg_long, reg_we;
  logic [9:0] reg_addr;
  logic [7:0] reg_wdata;

  int checks = 0, errors = 0, cycles = 0;
  int n_acc = 0, settle = 0, lat = 0;
  bit counting = 0;
  logic       lg_long[8], lg_we[8];
  logic [9:0] lg_addr[8];
  logic [7:0] lg_data[8];
  logic [7:0] rd_val;

  always #4 clk = ~clk;

  chan_switch_seq #(.CLK_MHZ(CLK_MHZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .channel(channel), .busy(busy),
    .done(done), .error(error), .reg_req(reg_req), .reg_long(reg_long),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_ack(reg_ack)
  );

  function automatic logic [7:0] exp_sel(input int ch);
    return 8'(((ch - 11) << 4) | 3);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (reg_ack) begin
      reg_ack <= 1'b0;
      lat = int'($urandom_range(3));
    end else if (reg_req) begin
      if (lat == 0) begin
        reg_ack   <= 1'b1;
        reg_rdata <= 8'($urandom);
      end else lat--;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (reg_req && reg_ack) begin
      if (n_acc < 8) begin
        lg_long[n_acc] = reg_long;
        lg_we[n_acc]   = reg_we;
        lg_addr[n_acc] = reg_addr;
        lg_data[n_acc] = reg_we ? reg_wdata : reg_rdata;
      end
      n_acc++;
      if (n_acc == 4) begin
        settle = 0;
        counting = 1;
      end
    end else if (counting) settle++;
  end

  initial begin
    #(8 * 180000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic run_seq(input int ch, input bit inject);
    int k = 0;
    bit busy_ok = 1;
    n_acc = 0;
    @(negedge clk); start = 1'b1; channel = 5'(ch);
    @(negedge clk); start = 1'b0; channel = 5'($urandom);
    chk(busy === 1'b1, "R9 busy after start", int'(busy), 1);
    while (done !== 1'b1) begin
      @(negedge clk);
      k++;
      if (done !== 1'b1 && busy !== 1'b1) busy_ok = 0;
      if (inject && k == 3) begin start = 1'b1; channel = 5'($urandom); end
      else if (inject && k == 2000) begin start = 1'b1; channel = 5'd3; end
      else start = 1'b0;
      if (error) busy_ok = 0;
    end
    counting = 0;
    chk(busy_ok, "R9/R10 busy held, no error", int'(busy_ok), 1);
    chk(busy === 1'b0, "R9 busy low at done", int'(busy), 0);
    chk(n_acc == 4, "R7/R10 access count", n_acc, 4);
    chk(lg_long[0] && lg_we[0] && lg_addr[0] == 10'h200 && lg_data[0] == exp_sel(ch),
        "R3 select write", int'(lg_data[0]), int'(exp_sel(ch)));
    rd_val = lg_data[1];
    chk(!lg_long[1] && !lg_we[1] && lg_addr[1] == 10'h036, "R4 control read",
        int'(lg_addr[1]), 'h036);
    chk(!lg_long[2] && lg_we[2] && lg_addr[2] == 10'h036 && lg_data[2] == (rd_val | 8'h04),
        "R5 reset set", int'(lg_data[2]), int'(rd_val | 8'h04));
    chk(!lg_long[3] && lg_we[3] && lg_addr[3] == 10'h036 && lg_data[3] == (rd_val & 8'hFB),
        "R6 reset clear", int'(lg_data[3]), int'(rd_val & 8'hFB));
    chk(settle == SETTLE_CYC, "R8 settle cycles", settle, SETTLE_CYC);
    @(negedge clk);
    chk(done === 1'b0, "R9 done single cycle", int'(done), 0);
    repeat (4) @(negedge clk);
    chk(!reg_req && !busy && n_acc == 4, "R10 no second sequence", n_acc, 4);
  endtask

  task automatic bad_ch(input int ch);
    n_acc = 0;
    @(negedge clk); start = 1'b1; channel = 5'(ch);
    @(negedge clk); start = 1'b0;
    chk(error === 1'b1 && !busy && !reg_req, "R2 error pulse", int'(error), 1);
    @(negedge clk);
    chk(error === 1'b0, "R2 error single cycle", int'(error), 0);
    repeat (3) @(negedge clk);
    chk(n_acc == 0 && !busy, "R2 no access", n_acc, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !error && !reg_req, "R1 reset state",
        int'({busy, done, error, reg_req}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !error && !reg_req, "R1 after release",
        int'({busy, done, error, reg_req}), 0);
    bad_ch(10);
    bad_ch(27);
    bad_ch(0);
    bad_ch(31);
    for (int i = 0; i < 3; i++) begin
      int c = int'($urandom_range(31));
      if (c < 11 || c > 26) bad_ch(c);
    end
    run_seq(11, 1'b0);
    run_seq(26, 1'b1);
    run_seq(int'($urandom_range(26, 11)), 1'b1);
    run_seq(int'($urandom_range(26, 11)), 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule